// File: doc/BRIEF.md
# Core Request/Response Socket

This block connects an IP core to an on-chip interconnect over a synchronous, point-to-point link in which each signal travels one way. The master side turns a one-cycle start pulse from its owner into a socket command (command code, address, write data). It holds that command on the wires until the slave side raises its accept. The slave side is backed by a register array. After a configurable number of wait cycles it accepts the command. It returns read responses, carrying a status code and data, a fixed number of cycles after acceptance.

Writes are posted and never produce a response. When the data-phase option is enabled, a write request goes out without its data. The data follows in a separately handshaked phase that comes strictly after the request. A read is complete only once its response phase has arrived. The master then hands the result to its owner with a one-cycle done pulse.

Top module: `core_socket`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, the command is idle (000), accept is low, the response is none (000), busy is low and done is low.
- R2: Once a command is on the socket, the master keeps the command code, address and data unchanged until a cycle in which accept is high. That cycle completes the request handshake.
- R3: The command is visible for exactly ACC_DELAY+1 cycles with accept low. Accept is then high for a single cycle.
- R4: A read of an address below DEPTH gives a response code of 001, holding the stored word, RD_LAT cycles after the handshake cycle. The owner sees done with the same word one cycle later.
- R5: A write produces no response code and no done pulse, and its data is returned by any later read of the same address.
- R6: A read of an address at or above DEPTH gives the response code 011 with zero data, and the owner sees done with the error flag set.
- R7: A write to an address at or above DEPTH changes no stored word.
- R8: With DATA_PHASE=1, the data-valid strobe rises in the cycle after the request handshake, while the command is already back to idle. The request, data and response phases never overlap.
- R9: The command codes are 000 for idle, 001 for write and 010 for read. The response field only ever carries 000, 001 or 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request from the owner, taken only when busy is low |
| start_write | input | 1 | 1 for write, 0 for read |
| start_addr | input | AW | Word address |
| start_wdata | input | DW | Write data |
| busy | output | 1 | Master has a transaction in progress |
| done_valid | output | 1 | One-cycle read completion pulse |
| done_rdata | output | DW | Read data returned with done |
| done_err | output | 1 | Read hit an address outside the array |
| sk_cmd | output | 3 | Socket command code |
| sk_accept | output | 1 | Socket command accept |
| sk_dvalid | output | 1 | Socket write data-phase valid |
| sk_resp | output | 3 | Socket response code |

## Verification
The assertions assume that the owner raises start only while busy is low, and that the master has only one transaction in flight. The slave's phase-exclusivity and hold checks depend on that serial behaviour. The stimulus issues each request only after busy has fallen. Every start pulse lasts exactly one cycle and is driven on the falling edge. Addresses cover the first and last in-range words and several points above DEPTH, so that both the error reads and the dropped writes are exercised.

// File: rtl/sock_pkg.sv
package sock_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE = 3'b000,
    CMD_WR   = 3'b001,
    CMD_RD   = 3'b010
  } cmd_e;

  typedef enum logic [2:0] {
    RSP_NONE = 3'b000,
    RSP_DVA  = 3'b001,
    RSP_ERR  = 3'b011
  } rsp_e;
endpackage

// File: rtl/sock_master.sv
module sock_master
  import sock_pkg::*;
#(
  parameter int AW         = 6,
  parameter int DW         = 16,
  parameter int DATA_PHASE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_write,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          busy,
  output logic          done_valid,
  output logic [DW-1:0] done_rdata,
  output logic          done_err,
  output logic [2:0]    m_cmd,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_data,
  output logic          m_dvalid,
  input  logic          s_accept,
  input  logic          s_daccept,
  input  logic [2:0]    s_resp,
  input  logic [DW-1:0] s_rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA, ST_WAIT} st_e;

  st_e           state;
  cmd_e          cmd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          dvalid_q;
  logic          dv_q;
  logic [DW-1:0] drd_q;
  logic          derr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cmd_q    <= CMD_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      dvalid_q <= 1'b0;
      dv_q     <= 1'b0;
      drd_q    <= '0;
      derr_q   <= 1'b0;
    end else begin
      dv_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          cmd_q  <= start_write ? CMD_WR : CMD_RD;
          addr_q <= start_addr;
          data_q <= start_wdata;
          state  <= ST_REQ;
        end
        ST_REQ: if (s_accept) begin
          cmd_q <= CMD_IDLE;
          if (cmd_q == CMD_WR) begin
            if (DATA_PHASE != 0) begin
              dvalid_q <= 1'b1;
              state    <= ST_DATA;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_DATA: if (s_daccept) begin
          dvalid_q <= 1'b0;
          state    <= ST_IDLE;
        end
        ST_WAIT: if (s_resp != RSP_NONE) begin
          dv_q   <= 1'b1;
          drd_q  <= s_rdata;
          derr_q <= (s_resp == RSP_ERR);
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done_valid = dv_q;
  assign done_rdata = drd_q;
  assign done_err   = derr_q;
  assign m_cmd      = cmd_q;
  assign m_addr     = addr_q;
  assign m_data     = data_q;
  assign m_dvalid   = dvalid_q;

  // R5: a response may only arrive while a read is waiting for it
  assert_resp_only_waiting_R5: assert property (@(posedge clk) disable iff (rst)
    (s_resp != RSP_NONE) |-> (state == ST_WAIT));

  // R8: the data phase starts only after the request has left the wires
  assert_data_after_req_R8: assert property (@(posedge clk) disable iff (rst)
    m_dvalid |-> (m_cmd == CMD_IDLE));
endmodule

// File: rtl/sock_responder.sv
module sock_responder
  import sock_pkg::*;
#(
  parameter int AW         = 6,
  parameter int DW         = 16,
  parameter int DEPTH      = 40,
  parameter int ACC_DELAY  = 2,
  parameter int RD_LAT     = 3,
  parameter int DATA_PHASE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    m_cmd,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_data,
  input  logic          m_dvalid,
  output logic          s_accept,
  output logic          s_daccept,
  output logic [2:0]    s_resp,
  output logic [DW-1:0] s_rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(ACC_DELAY + 1) + 1;

  logic          req_valid, hs, in_range, rd_hs;
  logic          acc_q;
  logic [CW-1:0] cnt_q;
  logic          we, re, data_hs;
  logic [IW-1:0] widx, ridx;
  logic [DW-1:0] wdat;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [RD_LAT-1:0]         pv, pe;
  logic [RD_LAT-1:0][IW-1:0] pi;

  assign req_valid = (m_cmd != CMD_IDLE);
  assign hs        = req_valid && acc_q;
  assign in_range  = ({1'b0, m_addr} < (AW+1)'(DEPTH));
  assign rd_hs     = hs && (m_cmd == CMD_RD);

  // accept after a fixed wait, as a single-cycle pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else if (acc_q) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else if (req_valid) begin
      if (cnt_q == CW'(ACC_DELAY)) begin
        acc_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
  assign s_accept = acc_q;

  generate
    if (DATA_PHASE != 0) begin : g_dphase
      logic          dacc_q;
      logic [IW-1:0] wa_q;
      logic          wok_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          dacc_q <= 1'b0;
          wa_q   <= '0;
          wok_q  <= 1'b0;
        end else begin
          dacc_q <= m_dvalid && !dacc_q;
          if (hs && m_cmd == CMD_WR) begin
            wa_q  <= m_addr[IW-1:0];
            wok_q <= in_range;
          end
        end
      end
      assign s_daccept = dacc_q;
      assign data_hs   = m_dvalid && dacc_q;
      assign we        = data_hs && wok_q;
      assign widx      = wa_q;
    end else begin : g_posted
      assign s_daccept = 1'b0;
      assign data_hs   = 1'b0;
      assign we        = hs && (m_cmd == CMD_WR) && in_range;
      assign widx      = m_addr[IW-1:0];
    end
  endgenerate
  assign wdat = m_data;

  // read metadata pipeline: stage k is visible k+1 cycles after the handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      pv[0] <= 1'b0;
      pe[0] <= 1'b0;
      pi[0] <= '0;
    end else begin
      pv[0] <= rd_hs;
      pe[0] <= !in_range;
      pi[0] <= m_addr[IW-1:0];
    end
  end

  generate
    for (genvar k = 1; k < RD_LAT; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          pv[k] <= 1'b0;
          pe[k] <= 1'b0;
          pi[k] <= '0;
        end else begin
          pv[k] <= pv[k-1];
          pe[k] <= pe[k-1];
          pi[k] <= pi[k-1];
        end
      end
    end
    if (RD_LAT == 1) begin : g_rd_now
      assign re   = rd_hs && in_range;
      assign ridx = m_addr[IW-1:0];
    end else begin : g_rd_late
      assign re   = pv[RD_LAT-2] && !pe[RD_LAT-2];
      assign ridx = pi[RD_LAT-2];
    end
  endgenerate

  // register array, written and read synchronously
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdat;
    if (re) rd_q <= mem[ridx];
  end

  assign s_resp  = pv[RD_LAT-1] ? (pe[RD_LAT-1] ? RSP_ERR : RSP_DVA) : RSP_NONE;
  assign s_rdata = (pv[RD_LAT-1] && !pe[RD_LAT-1]) ? rd_q : '0;

  // R2: a pending command stays still until it is accepted
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !acc_q) |=> (m_cmd == $past(m_cmd) && m_addr == $past(m_addr)
                               && m_data == $past(m_data)));

  // R3: accept is a single-cycle pulse and only answers a command
  assert_accept_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    acc_q |=> !acc_q);
  assert_accept_has_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    acc_q |-> req_valid);

  // R9: the response field carries only the three defined codes
  assert_resp_code_R9: assert property (@(posedge clk) disable iff (rst)
    (s_resp == RSP_NONE) || (s_resp == RSP_DVA) || (s_resp == RSP_ERR));

  // R8: request, data and response phases never share a cycle
  assert_phase_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hs, data_hs, (s_resp != RSP_NONE)}));
endmodule

// File: rtl/core_socket.sv
module core_socket #(
  parameter int AW         = 6,
  parameter int DW         = 16,
  parameter int DEPTH      = 40,
  parameter int ACC_DELAY  = 2,
  parameter int RD_LAT     = 3,
  parameter int DATA_PHASE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_write,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          busy,
  output logic          done_valid,
  output logic [DW-1:0] done_rdata,
  output logic          done_err,
  output logic [2:0]    sk_cmd,
  output logic          sk_accept,
  output logic          sk_dvalid,
  output logic [2:0]    sk_resp
);
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data, s_rdata;
  logic          s_daccept;

  sock_master #(.AW(AW), .DW(DW), .DATA_PHASE(DATA_PHASE)) u_mst (
    .clk(clk), .rst(rst), .start(start), .start_write(start_write),
    .start_addr(start_addr), .start_wdata(start_wdata), .busy(busy),
    .done_valid(done_valid), .done_rdata(done_rdata), .done_err(done_err),
    .m_cmd(sk_cmd), .m_addr(m_addr), .m_data(m_data), .m_dvalid(sk_dvalid),
    .s_accept(sk_accept), .s_daccept(s_daccept), .s_resp(sk_resp),
    .s_rdata(s_rdata)
  );

  sock_responder #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .ACC_DELAY(ACC_DELAY),
                   .RD_LAT(RD_LAT), .DATA_PHASE(DATA_PHASE)) u_slv (
    .clk(clk), .rst(rst), .m_cmd(sk_cmd), .m_addr(m_addr), .m_data(m_data),
    .m_dvalid(sk_dvalid), .s_accept(sk_accept), .s_daccept(s_daccept),
    .s_resp(sk_resp), .s_rdata(s_rdata)
  );
endmodule

// File: tb/sim_core_socket.sv
module sim_core_socket;
  localparam int AW = 6, DW = 16, DEPTH = 40, ACC_DELAY = 2, RD_LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, start_write = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] start_wdata = '0;
  logic busy, done_valid, done_err, sk_accept, sk_dvalid;
  logic [DW-1:0] done_rdata;
  logic [2:0] sk_cmd, sk_resp;

  core_socket #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .ACC_DELAY(ACC_DELAY),
                .RD_LAT(RD_LAT), .DATA_PHASE(1)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_write(start_write),
    .start_addr(start_addr), .start_wdata(start_wdata), .busy(busy),
    .done_valid(done_valid), .done_rdata(done_rdata), .done_err(done_err),
    .sk_cmd(sk_cmd), .sk_accept(sk_accept), .sk_dvalid(sk_dvalid), .sk_resp(sk_resp)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, acc_cyc = 0;
  bit finished = 1'b0;
  logic [DW:0] exp_q [$];   // {err, data}

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as done pulses appear
  always @(negedge clk) begin
    if (!rst && done_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected done", int'(done_rdata), 0);
      end else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        check(done_err == e[DW], "R6 done_err", int'(done_err), int'(e[DW]));
        check(done_rdata == e[DW-1:0], "R4 done_rdata", int'(done_rdata), int'(e[DW-1:0]));
        check(cyc - acc_cyc == RD_LAT + 1, "R4 latency", cyc - acc_cyc, RD_LAT + 1);
      end
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    bit held;
    logic [2:0] code;
    code = wr ? 3'b001 : 3'b010;
    @(negedge clk);
    start = 1'b1; start_write = wr; start_addr = a; start_wdata = d;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    held = 1'b1;
    while (!sk_accept) begin
      if (sk_cmd != code) held = 1'b0;
      n++;
      @(negedge clk);
    end
    acc_cyc = cyc;
    check(held && sk_cmd == code, "R2/R9 command held", int'(sk_cmd), int'(code));
    check(n == ACC_DELAY + 1, "R3 accept wait", n, ACC_DELAY + 1);
    @(negedge clk);
    check(!sk_accept, "R3 accept pulse", int'(sk_accept), 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1'b1, a, d);
    check(sk_dvalid && sk_cmd == 3'b000, "R8 data phase", int'({sk_dvalid, sk_cmd}), 8);
    for (int i = 0; i < 4; i++) begin
      check(sk_resp == 3'b000 && !done_valid, "R5 no response", int'(sk_resp), 0);
      @(negedge clk);
    end
    while (busy) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit err);
    exp_q.push_back({err, err ? {DW{1'b0}} : d});
    issue(1'b0, a, '0);
    repeat (RD_LAT - 1) @(negedge clk);
    check(sk_resp == (err ? 3'b011 : 3'b001), err ? "R6 resp code" : "R4 resp code",
          int'(sk_resp), err ? 3 : 1);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sk_cmd == 0 && !sk_accept && sk_resp == 0, "R1 socket idle in reset",
          int'({sk_cmd, sk_accept, sk_resp}), 0);
    check(!busy && !done_valid, "R1 owner idle in reset", int'({busy, done_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sk_cmd == 0 && !sk_accept && sk_resp == 0 && !busy, "R1 idle after reset",
          int'({sk_cmd, sk_accept, sk_resp, busy}), 0);

    do_write(6'd5, 16'hA1B2);
    do_write(6'd0, 16'h0001);
    do_write(6'd39, 16'hFFFF);
    do_write(6'd13, 16'h1313);
    do_read(6'd5, 16'hA1B2, 1'b0);
    do_read(6'd0, 16'h0001, 1'b0);
    do_read(6'd39, 16'hFFFF, 1'b0);
    // R7: writes above the array must not land anywhere
    do_write(6'd45, 16'hBEEF);
    do_write(6'd40, 16'hDEAD);
    do_read(6'd45, 16'h0, 1'b1);
    do_read(6'd63, 16'h0, 1'b1);
    do_read(6'd13, 16'h1313, 1'b0);
    do_read(6'd5, 16'hA1B2, 1'b0);
    do_read(6'd0, 16'h0001, 1'b0);
    // R5: posted overwrite seen by a later read
    for (int i = 0; i < 6; i++) do_write(6'(i * 7), 16'(16'h0F00 + i * 17));
    for (int i = 5; i >= 0; i--) do_read(6'(i * 7), 16'(16'h0F00 + i * 17), 1'b0);
    do_read(6'd39, 16'hFFFF, 1'b0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4 all reads completed", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule